// File: doc/BRIEF.md
# Quad Serial Memory Bring-Up Sequencer

This block runs once after power-on and brings two memories on a shared serial bus into four-bit command mode. One of them is a quad-capable flash and the other is a quad-capable SRAM. Each has its own active-low select. The block does not shift any bits itself. It hands one byte at a time to a separate shifter through a request/done handshake, and with each byte it gives the framing (single-bit or four-bit) and the direction (write or read). It also drives the two selects directly, so it decides where every frame begins and ends.

The script is fixed. For the flash it runs a soft reset, a write enable, a read-modify-write of the status byte that holds the quad-enable bit, a busy poll and then entry into four-bit mode. For the SRAM it forces the device out of four-bit mode and back in again. A sticky flag records success. Any later activation only re-enables the pin drivers and sends nothing. If the busy poll exceeds a programmable limit, the block stops and raises an error instead of ready.

Top module: `qmem_bringup_seq`

## Requirements
- R1: After reset, both selects are high, no request is issued, and `ready`, `error` and `pins_active` are all low.
- R2: The flash soft reset is two frames, each holding one byte, sent in four-bit framing (`cmd_quad`=1): 0x66 first and 0x99 second.
- R3: Next, a frame holding 0x06 is sent in single-bit framing. It is followed by a frame holding 0x35 and then one read byte (`cmd_read`=1).
- R4: A single single-bit frame then writes 0x01, 0x00 and the byte read under R3 with bit 1 forced to 1, in that order.
- R5: The flash is polled with frames of 0x05 followed by one read byte. Polling repeats while bit 0 of the read byte is 1. Only after a read with bit 0 equal to 0 is a single-bit frame holding 0x38 sent to the flash.
- R6: The SRAM then receives a frame holding 0xFF in four-bit framing, followed by a frame holding 0x38 in single-bit framing.
- R7: A request stays high with stable byte, framing and direction until `cmd_done`, and it drops in the next cycle. The two selects are never low together. Between frames, a select goes high for at least one cycle.
- R8: When the number of busy poll reads reaches `poll_limit`, `error` rises and stays high. After that no further request is made and `ready` stays low. A run with `poll_limit`-1 busy reads succeeds.
- R9: `ready` rises after the last SRAM frame and stays high. A later `activate` causes no bus traffic.
- R10: `bus_release` clears `pins_active` and `activate` sets it. `bus_release` wins if both are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| activate | input | 1 | Bring-up or re-activation request |
| bus_release | input | 1 | Give up the bus pins |
| poll_limit | input | TMO_W | Busy poll reads allowed before error |
| cmd_req | output | 1 | Byte request to the shifter |
| cmd_quad | output | 1 | 1: four-bit framing, 0: single-bit |
| cmd_read | output | 1 | 1: read a byte, 0: write `cmd_byte` |
| cmd_byte | output | 8 | Byte to send |
| cmd_done | input | 1 | Shifter finished the current byte |
| cmd_rdata | input | 8 | Byte read by the shifter |
| flash_cs_n | output | 1 | Flash select, active low |
| sram_cs_n | output | 1 | SRAM select, active low |
| pins_active | output | 1 | Bus pin drivers enabled |
| ready | output | 1 | Both devices are in four-bit mode |
| error | output | 1 | Busy poll timed out |

## Verification
The hardest situation to reach from the ports is the edge of the busy poll timeout. A run must see exactly `poll_limit`-1 busy reads and succeed, and another run must see exactly `poll_limit` busy reads and stop. This depends on the status bytes returned during polling, so the bench's shifter model answers each poll read from a scripted busy count. It sets that count to the limit and to one less than the limit, and it mixes in random status-2 bytes and random shifter latencies. The bench records every transfer, including its select, framing and frame boundary, and compares the record with an expected script built by bench functions.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GAP,
    S_ISSUE,
    S_BETW,
    S_ERR
  } seq_state_e;

  typedef struct packed {
    logic       tgt_sram;
    logic       quad;
    logic       rd;
    logic       last;
    logic       use_sr;
    logic [7:0] val;
  } step_t;

  localparam int unsigned STEP_W      = 4;
  localparam int unsigned N_STEPS     = 13;
  localparam logic [STEP_W-1:0] SR2_RD_STEP  = 4'd4;
  localparam logic [STEP_W-1:0] POLL_CMD_STEP = 4'd8;
  localparam logic [STEP_W-1:0] POLL_RD_STEP = 4'd9;
  localparam logic [STEP_W-1:0] LAST_STEP    = 4'(N_STEPS - 1);

  function automatic step_t mk(input logic s, input logic q, input logic r,
                               input logic l, input logic u, input logic [7:0] v);
    step_t t;
    t.tgt_sram = s; t.quad = q; t.rd = r; t.last = l; t.use_sr = u; t.val = v;
    return t;
  endfunction

  function automatic step_t script_step(input logic [STEP_W-1:0] i);
    case (i)
      4'd0:    return mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h66);
      4'd1:    return mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h99);
      4'd2:    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06);
      4'd3:    return mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h35);
      4'd4:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      4'd5:    return mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
      4'd6:    return mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      4'd7:    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      4'd8:    return mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
      4'd9:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      4'd10:   return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h38);
      4'd11:   return mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF);
      default: return mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h38);
    endcase
  endfunction

  function automatic logic [7:0] with_qe(input logic [7:0] v);
    return v | 8'h02;
  endfunction

  function automatic logic busy_bit(input logic [7:0] v);
    return v[0];
  endfunction

endpackage

// File: rtl/qbr_script.sv
module qbr_script
  import qbr_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output step_t             cur
);
  always_comb cur = script_step(step);
endmodule

// File: rtl/qbr_poll_timer.sv
module qbr_poll_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             busy_seen,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam int unsigned CW = TMO_W + 1;
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (busy_seen) cnt <= cnt + 1'b1;
  end

  always_comb expired = busy_seen && (({1'b0, cnt} + CW'(1)) >= {1'b0, limit});
endmodule

// File: rtl/qmem_bringup_seq.sv
module qmem_bringup_seq
  import qbr_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate,
  input  logic             bus_release,
  input  logic [TMO_W-1:0] poll_limit,
  output logic             cmd_req,
  output logic             cmd_quad,
  output logic             cmd_read,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_done,
  input  logic [7:0]       cmd_rdata,
  output logic             flash_cs_n,
  output logic             sram_cs_n,
  output logic             pins_active,
  output logic             ready,
  output logic             error
);
  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [7:0]        sr2;
  logic              quad_flag;
  step_t             cur;

  // named internal events
  logic step_fin, poll_busy, poll_expired, frame_sel;

  qbr_script u_script (.step(step), .cur(cur));

  qbr_poll_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE),
    .busy_seen(poll_busy), .limit(poll_limit), .expired(poll_expired)
  );

  always_comb begin
    step_fin  = (state == S_ISSUE) && cmd_done;
    poll_busy = step_fin && (step == POLL_RD_STEP) && busy_bit(cmd_rdata);
    frame_sel = (state == S_ISSUE) || (state == S_BETW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= '0;
      sr2         <= '0;
      quad_flag   <= 1'b0;
      pins_active <= 1'b0;
    end else begin
      if (bus_release)   pins_active <= 1'b0;
      else if (activate) pins_active <= 1'b1;
      case (state)
        S_IDLE: if (activate && !bus_release && !quad_flag) begin
          step  <= '0;
          state <= S_GAP;
        end
        S_GAP:  state <= S_ISSUE;
        S_BETW: state <= S_ISSUE;
        S_ISSUE: if (step_fin) begin
          if (step == SR2_RD_STEP) sr2 <= with_qe(cmd_rdata);
          if (poll_expired) state <= S_ERR;
          else if (poll_busy) begin
            step  <= POLL_CMD_STEP;
            state <= S_GAP;
          end else if (step == LAST_STEP) begin
            quad_flag <= 1'b1;
            state     <= S_IDLE;
          end else if (cur.last) begin
            step  <= step + 1'b1;
            state <= S_GAP;
          end else begin
            step  <= step + 1'b1;
            state <= S_BETW;
          end
        end
        default: state <= S_ERR;
      endcase
    end
  end

  always_comb begin
    cmd_req    = (state == S_ISSUE);
    cmd_quad   = cur.quad;
    cmd_read   = cur.rd;
    cmd_byte   = cur.use_sr ? sr2 : cur.val;
    flash_cs_n = !(frame_sel && !cur.tgt_sram);
    sram_cs_n  = !(frame_sel && cur.tgt_sram);
    ready      = quad_flag;
    error      = (state == S_ERR);
  end
endmodule

// File: rtl/qbr_checker.sv
module qbr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_req,
  input logic       cmd_done,
  input logic       cmd_quad,
  input logic       cmd_read,
  input logic [7:0] cmd_byte,
  input logic       flash_cs_n,
  input logic       sram_cs_n,
  input logic       pins_active,
  input logic       bus_release,
  input logic       ready,
  input logic       error,
  input logic       poll_expired
);
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_cs_n && !sram_cs_n));
  a_r7_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (!flash_cs_n || !sram_cs_n));
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_done |=> cmd_req && $stable(cmd_byte) && $stable(cmd_quad) && $stable(cmd_read));
  a_r7_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_done |=> !cmd_req);
  a_r7_switch_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n) |-> $past(sram_cs_n));
  a_r8_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> error && !cmd_req);
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !ready && !cmd_req);
  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !cmd_req && flash_cs_n && sram_cs_n);
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !pins_active);
endmodule

bind qmem_bringup_seq qbr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_done(cmd_done),
  .cmd_quad(cmd_quad), .cmd_read(cmd_read), .cmd_byte(cmd_byte),
  .flash_cs_n(flash_cs_n), .sram_cs_n(sram_cs_n), .pins_active(pins_active),
  .bus_release(bus_release), .ready(ready), .error(error),
  .poll_expired(poll_expired)
);

// File: tb/qmem_bringup_seq_test.sv
`timescale 1ns/1ps
module qmem_bringup_seq_test;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic activate = 1'b0, bus_release = 1'b0;
  logic [TMO_W-1:0] poll_limit = 16'd4;
  logic cmd_req, cmd_quad, cmd_read, cmd_done;
  logic [7:0] cmd_byte, cmd_rdata;
  logic flash_cs_n, sram_cs_n, pins_active, ready, error;

  always #2.5 clk = ~clk;

  qmem_bringup_seq #(.TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n), .activate(activate), .bus_release(bus_release),
    .poll_limit(poll_limit), .cmd_req(cmd_req), .cmd_quad(cmd_quad),
    .cmd_read(cmd_read), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata), .flash_cs_n(flash_cs_n), .sram_cs_n(sram_cs_n),
    .pins_active(pins_active), .ready(ready), .error(error)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;

  // record entry: {new_frame, sram, quad, read, byte}
  logic [11:0] got [0:63];
  logic [11:0] exp_q [0:63];
  int got_n = 0, exp_n = 0;
  logic gap_seen = 1'b1;
  logic [7:0] m_sr2 = 8'h00, last_wr = 8'h00;
  int busy_left = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // frame boundary monitor
  always @(negedge clk) if (flash_cs_n && sram_cs_n) gap_seen <= 1'b1;

  // shifter model
  initial begin
    cmd_done = 1'b0;
    cmd_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_req) begin
        if (got_n < 64)
          got[got_n] = {gap_seen, !sram_cs_n, cmd_quad, cmd_read, cmd_read ? 8'h00 : cmd_byte};
        got_n++;
        gap_seen = 1'b0;
        if (!cmd_read) last_wr = cmd_byte;
        else if (last_wr == 8'h35) cmd_rdata = m_sr2;
        else if (busy_left > 0) begin
          cmd_rdata = 8'($urandom) | 8'h01;
          busy_left--;
        end else cmd_rdata = 8'($urandom) & 8'hFE;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
      end
    end
  end

  function automatic logic [11:0] ent(input bit nf, input bit s, input bit q,
                                      input bit r, input logic [7:0] b);
    return {nf, s, q, r, b};
  endfunction

  task automatic push(input logic [11:0] e);
    exp_q[exp_n] = e;
    exp_n++;
  endtask

  function automatic string tag_of(input int i, input int npoll);
    if (i < 2) return "R2";
    if (i < 5) return "R3";
    if (i < 8) return "R4";
    if (i < 8 + 2*npoll + 1) return "R5";
    return "R6";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    activate = 1'b0;
    bus_release = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_act();
    activate = 1'b1;
    @(negedge clk);
    activate = 1'b0;
  endtask

  task automatic run_case(input logic [7:0] sr2v, input int busy_n,
                          input int limit, input bit expect_err);
    int npoll;
    do_reset();
    poll_limit = TMO_W'(limit);
    m_sr2 = sr2v;
    busy_left = busy_n;
    got_n = 0;
    exp_n = 0;
    npoll = expect_err ? limit : busy_n + 1;
    push(ent(1, 0, 1, 0, 8'h66));
    push(ent(1, 0, 1, 0, 8'h99));
    push(ent(1, 0, 0, 0, 8'h06));
    push(ent(1, 0, 0, 0, 8'h35));
    push(ent(0, 0, 0, 1, 8'h00));
    push(ent(1, 0, 0, 0, 8'h01));
    push(ent(0, 0, 0, 0, 8'h00));
    push(ent(0, 0, 0, 0, sr2v | 8'h02));
    for (int p = 0; p < npoll; p++) begin
      push(ent(1, 0, 0, 0, 8'h05));
      push(ent(0, 0, 0, 1, 8'h00));
    end
    if (!expect_err) begin
      push(ent(1, 0, 0, 0, 8'h38));
      push(ent(1, 1, 1, 0, 8'hFF));
      push(ent(1, 1, 0, 0, 8'h38));
    end
    pulse_act();
    for (int w = 0; w < 3000 && !ready && !error; w++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got_n == exp_n, expect_err ? "R8 transfer count" : "R5 transfer count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got[i] == exp_q[i], tag_of(i, npoll), int'(got[i]), int'(exp_q[i]));
    chk(ready == !expect_err, "R9 ready", ready, !expect_err);
    chk(error == expect_err, "R8 error", error, expect_err);
    chk(pins_active == 1'b1, "R10 pins after activate", pins_active, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(flash_cs_n && sram_cs_n, "R1 selects high", {flash_cs_n, sram_cs_n}, 3);
    chk(!cmd_req, "R1 no request", cmd_req, 0);
    chk(!ready && !error && !pins_active, "R1 flags low", {ready, error, pins_active}, 0);
    do_reset();
    chk(flash_cs_n && sram_cs_n && !cmd_req, "R1 after reset", {flash_cs_n, sram_cs_n, cmd_req}, 6);

    // directed: status 0x00, two busy reads, boundary limit-1 busy succeeds
    run_case(8'h00, 2, 3, 1'b0);

    // R9/R10 re-activation after ready
    bus_release = 1'b1;
    @(negedge clk);
    bus_release = 1'b0;
    chk(!pins_active, "R10 release", pins_active, 0);
    got_n = 0;
    pulse_act();
    chk(pins_active, "R10 reactivate", pins_active, 1);
    repeat (40) @(negedge clk);
    chk(got_n == 0, "R9 no traffic on reactivation", got_n, 0);
    chk(ready, "R9 ready held", ready, 1);
    activate = 1'b1;
    bus_release = 1'b1;
    @(negedge clk);
    activate = 1'b0;
    bus_release = 1'b0;
    chk(!pins_active, "R10 release wins", pins_active, 0);

    // R8 timeout exactly at the limit
    run_case(8'hA5, 3, 3, 1'b1);
    got_n = 0;
    pulse_act();
    repeat (30) @(negedge clk);
    chk(got_n == 0 && error, "R8 stopped after error", got_n, 0);

    // directed: status already with QE set, no busy
    run_case(8'hFF, 0, 1, 1'b0);
    // limit of one with one busy read errors
    run_case(8'h40, 1, 1, 1'b1);

    // random cases
    for (int k = 0; k < 8; k++) begin
      int lim;
      int bz;
      bit er;
      lim = $urandom_range(1, 6);
      er = ($urandom_range(0, 2) == 0);
      bz = er ? lim : $urandom_range(0, lim - 1);
      run_case(8'($urandom), bz, lim, er);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule